// File: doc/BRIEF.md
# JTAG Test Access Port with Reset Chain

This block is a JTAG test access port controller. It has a 4-bit instruction register and three data registers: a one-bit bypass stage, a fixed 32-bit identification register, and a one-bit reset chain. The reset chain drives a device-level reset request. A debugger moves the controller through its 16-state machine with TMS and shifts bits in on TDI and out on TDO. When it selects the reset instruction and shifts a one into the chain, the rest of the chip is held in reset. The TAP logic itself is not reset by this request, so scans carry on normally while the reset is held.

The controller samples TMS on each rising TCK edge. The next-state rules are:

| State | TMS = 0 | TMS = 1 |
|---|---|---|
| Reset | Idle | Reset |
| Idle | Idle | DrSelect |
| DrSelect | DrCapture | IrSelect |
| DrCapture | DrShift | DrExit1 |
| DrShift | DrShift | DrExit1 |
| DrExit1 | DrPause | DrUpdate |
| DrPause | DrPause | DrExit2 |
| DrExit2 | DrShift | DrUpdate |
| DrUpdate | Idle | DrSelect |
| IrSelect | IrCapture | Reset |
| IrCapture | IrShift | IrExit1 |
| IrShift | IrShift | IrExit1 |
| IrExit1 | IrPause | IrUpdate |
| IrPause | IrPause | IrExit2 |
| IrExit2 | IrShift | IrUpdate |
| IrUpdate | Idle | DrSelect |

The reset request is taken straight from the chain's single flop. No update latch sits between them, so the request follows every bit shifted through the chain.

Top module: `jtag_rst_tap`

## Requirements
- R1: The state machine follows the transition table above on each rising TCK edge, including the paths through DrPause and DrExit2 back into DrShift. Bits shift only in the shift states.
- R2: Five rising TCK edges with TMS high reach the Reset state from any state. The next edge with TMS low reaches Idle with the bypass instruction (0xF) loaded.
- R3: trst_n low immediately forces the Reset state, loads the bypass instruction, clears the reset chain and deasserts sys_rst_req.
- R4: IrCapture loads 4'b0001 into the instruction shift register. That value leaves on TDO least significant bit first. The instruction only changes in IrUpdate.
- R5: Instruction 0xC selects the one-bit reset chain. In DrShift it takes TDI on the rising edge and presents its previous value on TDO. DrCapture leaves it unchanged.
- R6: While 0xC is the current instruction, sys_rst_req equals the chain bit and follows it in the cycle it shifts, without waiting for DrUpdate.
- R7: An asserted sys_rst_req does not disturb the controller. An IR scan still captures 4'b0001, the instruction is kept, and the chain still shifts.
- R8: Instruction 0xF and every unassigned code (anything other than 0x1 and 0xC) select the one-bit bypass register. It captures 0 in DrCapture, so TDO is TDI delayed by one shift.
- R9: Instruction 0x1 selects the 32-bit identification register. It captures the constant ID_VALUE, which is shifted out least significant bit first.
- R10: TDO and tdo_en change only on falling TCK edges. tdo_en is high exactly while the state is DrShift or IrShift. Otherwise tdo sits at the idle level TDO_IDLE (default 1).
- R11: idle_flag is high exactly while the controller is in the Idle state.
- R12: Loading any instruction other than 0xC deasserts sys_rst_req. Entering Reset clears the chain, so a later load of 0xC starts with the request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low TAP reset (used when USE_TRST=1) |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while a shift state drives TDO |
| sys_rst_req | output | 1 | Device reset request from the reset chain |
| idle_flag | output | 1 | High while in the Idle state |

## Verification
The bench shifts a zero into the chain during DrShift and checks that sys_rst_req drops before DrUpdate. A design with an update latch would keep the request high there. It reloads the reset instruction while the reset is held and checks that the IR capture pattern and the chain contents survive. A design whose reset request fed back into the TAP would lose them. It sends five TMS-high edges from inside a 32-bit identification scan and then checks that a 2-bit scan comes back through bypass. A register left selected would return identification bits instead. It also runs a scan through DrPause and DrExit2, and it samples TDO just after a rising edge. A design that updated TDO on the wrong edge, or enabled it outside the shift states, would be caught there.

// File: rtl/jtag_rst_pkg.sv
package jtag_rst_pkg;

    localparam int IR_W = 4;

    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_IDCODE   = 4'h1;
    localparam instr_t OP_RSTCHAIN = 4'hC;
    localparam instr_t OP_BYPASS   = 4'hF;
    localparam instr_t IR_CAPTURE  = 4'b0001;

    typedef enum logic [3:0] {
        ST_RESET     = 4'd0,
        ST_IDLE      = 4'd1,
        ST_DR_SELECT = 4'd2,
        ST_DR_CAP    = 4'd3,
        ST_DR_SHIFT  = 4'd4,
        ST_DR_EXIT1  = 4'd5,
        ST_DR_PAUSE  = 4'd6,
        ST_DR_EXIT2  = 4'd7,
        ST_DR_UPD    = 4'd8,
        ST_IR_SELECT = 4'd9,
        ST_IR_CAP    = 4'd10,
        ST_IR_SHIFT  = 4'd11,
        ST_IR_EXIT1  = 4'd12,
        ST_IR_PAUSE  = 4'd13,
        ST_IR_EXIT2  = 4'd14,
        ST_IR_UPD    = 4'd15
    } tap_state_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_rst_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e st_q,
    output logic       go_reset,
    output logic       capture_dr,
    output logic       shift_dr,
    output logic       capture_ir,
    output logic       shift_ir,
    output logic       update_ir
);

    tap_state_e st_d;

    // state register
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    // next state from TMS
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RESET:     st_d = tms ? ST_RESET     : ST_IDLE;
            ST_IDLE:      st_d = tms ? ST_DR_SELECT : ST_IDLE;
            ST_DR_SELECT: st_d = tms ? ST_IR_SELECT : ST_DR_CAP;
            ST_DR_CAP:    st_d = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_SHIFT:  st_d = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_EXIT1:  st_d = tms ? ST_DR_UPD    : ST_DR_PAUSE;
            ST_DR_PAUSE:  st_d = tms ? ST_DR_EXIT2  : ST_DR_PAUSE;
            ST_DR_EXIT2:  st_d = tms ? ST_DR_UPD    : ST_DR_SHIFT;
            ST_DR_UPD:    st_d = tms ? ST_DR_SELECT : ST_IDLE;
            ST_IR_SELECT: st_d = tms ? ST_RESET     : ST_IR_CAP;
            ST_IR_CAP:    st_d = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_SHIFT:  st_d = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_EXIT1:  st_d = tms ? ST_IR_UPD    : ST_IR_PAUSE;
            ST_IR_PAUSE:  st_d = tms ? ST_IR_EXIT2  : ST_IR_PAUSE;
            ST_IR_EXIT2:  st_d = tms ? ST_IR_UPD    : ST_IR_SHIFT;
            ST_IR_UPD:    st_d = tms ? ST_DR_SELECT : ST_IDLE;
            default:      st_d = ST_RESET;
        endcase
    end

    // control decode
    always_comb begin
        go_reset   = (st_d == ST_RESET);
        capture_dr = 1'b0;
        shift_dr   = 1'b0;
        capture_ir = 1'b0;
        shift_ir   = 1'b0;
        update_ir  = 1'b0;
        unique case (st_q)
            ST_DR_CAP:   capture_dr = 1'b1;
            ST_DR_SHIFT: shift_dr   = 1'b1;
            ST_IR_CAP:   capture_ir = 1'b1;
            ST_IR_SHIFT: shift_ir   = 1'b1;
            ST_IR_UPD:   update_ir  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_rst_pkg::*;
(
    input  logic   tck,
    input  logic   rst_n,
    input  logic   tdi,
    input  logic   go_reset,
    input  logic   capture_ir,
    input  logic   shift_ir,
    input  logic   update_ir,
    output instr_t ir_q,
    output logic   ir_tdo
);

    instr_t ir_sh;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            ir_sh <= IR_CAPTURE;
            ir_q  <= OP_BYPASS;
        end else begin
            if (capture_ir) begin
                ir_sh <= IR_CAPTURE;
            end else if (shift_ir) begin
                ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            end
            if (go_reset) begin
                ir_q <= OP_BYPASS;
            end else if (update_ir) begin
                ir_q <= ir_sh;
            end
        end
    end

    assign ir_tdo = ir_sh[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import jtag_rst_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h4E2D_9A37
) (
    input  logic   tck,
    input  logic   rst_n,
    input  logic   tdi,
    input  logic   go_reset,
    input  logic   capture_dr,
    input  logic   shift_dr,
    input  instr_t ir_q,
    output logic   dr_tdo,
    output logic   sys_rst_req
);

    logic            sel_rst;
    logic            sel_id;
    logic            sel_byp;
    logic            byp_q;
    logic            chain_q;
    logic [ID_W-1:0] id_sh;

    always_comb begin
        sel_rst = (ir_q == OP_RSTCHAIN);
        sel_id  = (ir_q == OP_IDCODE);
        sel_byp = !sel_rst && !sel_id;
    end

    // bypass stage
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else if (capture_dr && sel_byp) begin
            byp_q <= 1'b0;
        end else if (shift_dr && sel_byp) begin
            byp_q <= tdi;
        end
    end

    // identification register
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            id_sh <= ID_VALUE;
        end else if (capture_dr && sel_id) begin
            id_sh <= ID_VALUE;
        end else if (shift_dr && sel_id) begin
            id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
    end

    // reset chain: no capture, no update stage
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= 1'b0;
        end else if (go_reset) begin
            chain_q <= 1'b0;
        end else if (shift_dr && sel_rst) begin
            chain_q <= tdi;
        end
    end

    always_comb begin
        if (sel_rst) begin
            dr_tdo = chain_q;
        end else if (sel_id) begin
            dr_tdo = id_sh[0];
        end else begin
            dr_tdo = byp_q;
        end
    end

    assign sys_rst_req = sel_rst && chain_q;

endmodule

// File: rtl/jtag_rst_tap.sv
module jtag_rst_tap
    import jtag_rst_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h4E2D_9A37,
    parameter bit              USE_TRST = 1'b1,
    parameter bit              TDO_IDLE = 1'b1
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    output logic sys_rst_req,
    output logic idle_flag
);

    logic       rst_n;
    tap_state_e st_q;
    logic       go_reset;
    logic       capture_dr;
    logic       shift_dr;
    logic       capture_ir;
    logic       shift_ir;
    logic       update_ir;
    instr_t     ir_q;
    logic       ir_tdo;
    logic       dr_tdo;

    generate
        if (USE_TRST) begin : g_trst
            assign rst_n = trst_n;
        end else begin : g_no_trst
            assign rst_n = 1'b1;
        end
    endgenerate

    tap_fsm u_fsm (
        .tck        (tck),
        .rst_n      (rst_n),
        .tms        (tms),
        .st_q       (st_q),
        .go_reset   (go_reset),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .capture_ir (capture_ir),
        .shift_ir   (shift_ir),
        .update_ir  (update_ir)
    );

    tap_ir u_ir (
        .tck        (tck),
        .rst_n      (rst_n),
        .tdi        (tdi),
        .go_reset   (go_reset),
        .capture_ir (capture_ir),
        .shift_ir   (shift_ir),
        .update_ir  (update_ir),
        .ir_q       (ir_q),
        .ir_tdo     (ir_tdo)
    );

    tap_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck         (tck),
        .rst_n       (rst_n),
        .tdi         (tdi),
        .go_reset    (go_reset),
        .capture_dr  (capture_dr),
        .shift_dr    (shift_dr),
        .ir_q        (ir_q),
        .dr_tdo      (dr_tdo),
        .sys_rst_req (sys_rst_req)
    );

    // serial output on the falling edge
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tdo    <= TDO_IDLE;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shift_ir || shift_dr;
            if (shift_ir) begin
                tdo <= ir_tdo;
            end else if (shift_dr) begin
                tdo <= dr_tdo;
            end else begin
                tdo <= TDO_IDLE;
            end
        end
    end

    assign idle_flag = (st_q == ST_IDLE);

endmodule

// File: rtl/jtag_rst_tap_chk.sv
module jtag_rst_tap_chk
    import jtag_rst_pkg::*;
(
    input logic       tck,
    input logic       rst_n,
    input logic       tms,
    input logic       tdi,
    input logic       tdo_en,
    input logic       sys_rst_req,
    input tap_state_e st_q,
    input logic       go_reset,
    input instr_t     ir_q
);

    logic [2:0] tms_run;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tms_run <= 3'd0;
        end else if (!tms) begin
            tms_run <= 3'd0;
        end else if (tms_run < 3'd5) begin
            tms_run <= tms_run + 3'd1;
        end
    end

    assert_five_tms_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (tms_run >= 3'd5) |-> (st_q == ST_RESET));

    assert_ir_hold_R4: assert property (@(posedge tck) disable iff (!rst_n)
        ((st_q != ST_IR_UPD) && !go_reset) |=> $stable(ir_q));

    assert_chain_shift_R5: assert property (@(posedge tck) disable iff (!rst_n)
        ((st_q == ST_DR_SHIFT) && (ir_q == OP_RSTCHAIN)) |=> (sys_rst_req == $past(tdi)));

    assert_rst_instr_R12: assert property (@(posedge tck) disable iff (!rst_n)
        sys_rst_req |-> (ir_q == OP_RSTCHAIN));

    assert_reset_quiet_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (st_q == ST_RESET) |-> !sys_rst_req);

    assert_tdo_window_R10: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en == ((st_q == ST_DR_SHIFT) || (st_q == ST_IR_SHIFT)));

endmodule

bind jtag_rst_tap jtag_rst_tap_chk u_chk (
    .tck         (tck),
    .rst_n       (rst_n),
    .tms         (tms),
    .tdi         (tdi),
    .tdo_en      (tdo_en),
    .sys_rst_req (sys_rst_req),
    .st_q        (st_q),
    .go_reset    (go_reset),
    .ir_q        (ir_q)
);

// File: tb/test_jtag_rst_tap.sv
`timescale 1ns/1ps
module test_jtag_rst_tap;

    localparam logic [31:0] BENCH_ID = 32'h4E2D_9A37;

    logic tck;
    logic trst_n;
    logic tms;
    logic tdi;
    logic tdo;
    logic tdo_en;
    logic sys_rst_req;
    logic idle_flag;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    jtag_rst_tap #(
        .ID_W     (32),
        .ID_VALUE (BENCH_ID),
        .USE_TRST (1'b1),
        .TDO_IDLE (1'b1)
    ) i_jtag_rst_tap (
        .tck         (tck),
        .trst_n      (trst_n),
        .tms         (tms),
        .tdi         (tdi),
        .tdo         (tdo),
        .tdo_en      (tdo_en),
        .sys_rst_req (sys_rst_req),
        .idle_flag   (idle_flag)
    );

    initial begin
        tck = 1'b0;
        forever #4 tck = ~tck;
    end

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic v, input string tag);
        exp_t e;
        e.v   = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // drive after the falling edge, return 2 ns after the rising edge
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        @(posedge tck);
        #2;
    endtask

    task automatic tms_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    endtask

    // from Idle, back to Idle
    task automatic scan_ir(input logic [3:0] code);
        push(1'b1, "R4");
        push(1'b0, "R4");
        push(1'b0, "R4");
        push(1'b0, "R4");
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(i == 3, code[i]);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din,
                           input logic [31:0] dexp, input string tag);
        for (int i = 0; i < n; i++) push(dexp[i], tag);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    // monitor: compare each shifted-out bit with the queue
    initial begin
        forever begin
            @(negedge tck);
            #2;
            if (trst_n) begin
                if (tdo_en) begin
                    if (exp_q.size() == 0) begin
                        check_eq("R10", "tdo_en high with nothing expected", 32'(tdo_en), 32'd0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check_eq(e.tag, "shifted TDO bit", 32'(tdo), 32'(e.v));
                    end
                end else begin
                    check_eq("R10", "idle TDO level", 32'(tdo), 32'd1);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        trst_n = 1'b0;
        tms    = 1'b1;
        tdi    = 1'b0;
        #10;
        check_eq("R3", "reset sys_rst_req", 32'(sys_rst_req), 32'd0);
        check_eq("R3", "reset tdo_en", 32'(tdo_en), 32'd0);
        check_eq("R3", "reset tdo", 32'(tdo), 32'd1);
        check_eq("R11", "idle_flag in Reset", 32'(idle_flag), 32'd0);
        #11;
        trst_n = 1'b1;

        step(1'b0, 1'b0);
        check_eq("R11", "idle_flag in Idle", 32'(idle_flag), 32'd1);
        check_eq("R1", "Idle holds with TMS low", 32'(idle_flag), 32'd1);
        step(1'b0, 1'b0);
        check_eq("R11", "idle_flag still Idle", 32'(idle_flag), 32'd1);

        // default instruction is bypass
        scan_dr(8, 32'h0000_00B2, 32'h0000_0164, "R8");

        // identification register
        scan_ir(4'h1);
        scan_dr(32, 32'h0, BENCH_ID, "R9");

        // unassigned code selects bypass
        scan_ir(4'h5);
        scan_dr(4, 32'h0000_000D, 32'h0000_000A, "R8");

        // pause path: Shift, Exit1, Pause, Pause, Exit2, Shift, Exit1
        push(1'b0, "R1");
        push(1'b1, "R1");
        push(1'b0, "R1");
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        check_eq("R10", "TDO holds across rising edge", 32'(tdo), 32'd0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check_eq("R1", "no idle in DrPause", 32'(idle_flag), 32'd0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check_eq("R1", "back to Idle after DrUpdate", 32'(idle_flag), 32'd1);

        // five TMS high from inside an identification scan
        scan_ir(4'h1);
        push(BENCH_ID[0], "R9");
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        tms_reset();
        check_eq("R2", "not Idle after five TMS high", 32'(idle_flag), 32'd0);
        step(1'b0, 1'b0);
        check_eq("R2", "Idle after Reset", 32'(idle_flag), 32'd1);
        scan_dr(2, 32'h3, 32'h2, "R2");

        // reset chain
        scan_ir(4'hC);
        check_eq("R12", "chain starts clear", 32'(sys_rst_req), 32'd0);
        scan_dr(1, 32'h1, 32'h0, "R5");
        check_eq("R6", "request after shifting one", 32'(sys_rst_req), 32'd1);

        push(1'b1, "R5");
        push(1'b0, "R5");
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check_eq("R5", "DrCapture keeps chain", 32'(sys_rst_req), 32'd1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check_eq("R6", "request drops in DrShift", 32'(sys_rst_req), 32'd0);
        step(1'b1, 1'b1);
        check_eq("R6", "request rises before DrUpdate", 32'(sys_rst_req), 32'd1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);

        // controller unaffected while reset held
        scan_ir(4'hC);
        check_eq("R7", "request kept over IR scan", 32'(sys_rst_req), 32'd1);
        scan_dr(1, 32'h1, 32'h1, "R7");
        check_eq("R7", "chain still shifts", 32'(sys_rst_req), 32'd1);

        // other instruction and Reset clear the request
        scan_ir(4'hF);
        check_eq("R12", "request off with bypass", 32'(sys_rst_req), 32'd0);
        tms_reset();
        step(1'b0, 1'b0);
        scan_ir(4'hC);
        check_eq("R12", "chain cleared by Reset", 32'(sys_rst_req), 32'd0);

        // asynchronous TRST
        scan_dr(1, 32'h1, 32'h0, "R5");
        check_eq("R6", "request before TRST", 32'(sys_rst_req), 32'd1);
        @(negedge tck);
        #1;
        trst_n = 1'b0;
        #1;
        check_eq("R3", "TRST clears request", 32'(sys_rst_req), 32'd0);
        check_eq("R3", "TRST leaves Idle", 32'(idle_flag), 32'd0);
        #4;
        trst_n = 1'b1;
        step(1'b0, 1'b0);
        scan_dr(2, 32'h1, 32'h2, "R3");

        check_eq("R10", "all expected bits shifted", 32'(exp_q.size()), 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule